// File: doc/BRIEF.md
# Pipeline Hazard Stall and Squash Controller

This controller sits beside the pipeline registers of a five-stage in-order core. Each cycle it looks at three things. The first is the source register indices of the instruction held in the fetch/decode register. The second is the load flag and destination index of the instruction held in the decode/execute register. The third is the taken indication and target address from the branch comparator. From these it produces the enables and clears that the pipeline registers sample on the next rising clock edge. All control outputs are combinational.

A load whose result is needed by the very next instruction freezes fetch and decode for one cycle and sends a no-op into execute. After that cycle the value comes from the late forwarding path. A taken branch redirects the program counter and squashes the wrongly fetched younger instructions. The number squashed depends on two things. One is whether branches resolve in execute or in decode, chosen by a parameter. The other is whether a single architectural delay slot is enabled, chosen by a second parameter. The controller keeps its own occupancy bits for the two pipeline registers it governs. These bits let it ignore hazards and branch indications that come from empty slots.

Top module: `hzd_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, both occupancy outputs are 0. In that cycle no stall, flush or redirect is raised, and both `pc_we_o` and `ifid_we_o` are 1.
- R2: A load-use hazard exists when both occupancy bits are 1, `idex_load_i` is 1, and `idex_rd_i` equals `ifid_rs1_i` or `ifid_rs2_i`. A non-load or a mismatch is not a hazard.
- R3: During a stall cycle, `pc_we_o` = 0, `ifid_we_o` = 0 and `idex_bubble_o` = 1.
- R4: A stall lasts exactly one cycle. In the cycle after a stall, the decode/execute occupancy is 0 and no stall is raised for the same inputs.
- R5: A load whose destination is register index 0 never causes a stall.
- R6: Branches resolving in execute with no delay slot: a taken branch raises `ifid_flush_o`, `idex_flush_o`, `pc_redirect_o` and `pc_we_o`, and `pc_target_o` equals `br_target_i`. When there is no redirect, `pc_target_o` is 0.
- R7: Branches resolving in decode with no delay slot: a taken branch raises `ifid_flush_o` and the redirect, but not `idex_flush_o`.
- R8: With the delay slot enabled, the squash depth drops by one. An execute-resolved branch raises only `ifid_flush_o`. A decode-resolved branch raises no flush, so the slot instruction always proceeds.
- R9: When a taken branch and a load-use hazard coincide, the branch wins. The redirect and flushes are raised and no stall is raised.
- R10: A taken indication is ignored when the occupancy bit of the resolving stage is 0. That bit is decode/execute for execute resolution and fetch/decode for decode resolution.
- R11: The next fetch/decode occupancy is 0 on a flush, 1 on a write, and otherwise held. The next decode/execute occupancy is 0 on a bubble or flush, and otherwise copies the fetch/decode occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ifid_rs1_i | input | RW | First source index of the instruction in fetch/decode |
| ifid_rs2_i | input | RW | Second source index of the instruction in fetch/decode |
| idex_load_i | input | 1 | Instruction in decode/execute is a load |
| idex_rd_i | input | RW | Destination index of the instruction in decode/execute |
| br_taken_i | input | 1 | Branch comparator reports taken |
| br_target_i | input | AW | Branch target address |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Load a no-op into decode/execute for a stall |
| ifid_flush_o | output | 1 | Squash the fetch/decode register |
| idex_flush_o | output | 1 | Squash the decode/execute register |
| pc_redirect_o | output | 1 | Select branch target as next PC |
| pc_target_o | output | AW | Redirect address, 0 when not redirecting |
| ifid_vld_o | output | 1 | Fetch/decode occupancy |
| idex_vld_o | output | 1 | Decode/execute occupancy |

## Verification
The assertions check the following on every cycle: the freeze pattern of a stall, its one-cycle length, the register 0 exemption, branch priority over a stall, the redirect target, and the clearing of occupancy after a flush or bubble. Each configuration's squash depth is also asserted inside its own generate branch. Four things can only be shown by the bench's scenarios, run against four configurations side by side: whether a given index pattern is a hazard at all, how occupancy refills after reset, whether a branch from an empty slot is ignored, and that decode and execute resolution differ in flush depth under identical stimulus.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic {
    RES_EX = 1'b0,
    RES_ID = 1'b1
  } res_stage_e;

  function automatic int squash_depth(res_stage_e stage, bit dslot);
    return (stage == RES_EX ? 2 : 1) - (dslot ? 1 : 0);
  endfunction
endpackage

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ifid_vld_i,
  input  logic          idex_vld_i,
  input  logic [RW-1:0] rs1_i,
  input  logic [RW-1:0] rs2_i,
  input  logic          load_i,
  input  logic [RW-1:0] rd_i,
  output logic          luse_o
);
  logic rd_nz, hit;

  assign rd_nz  = |rd_i;
  assign hit    = (rd_i == rs1_i) || (rd_i == rs2_i);
  assign luse_o = ifid_vld_i && idex_vld_i && load_i && rd_nz && hit;

  // R5
  zero_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i == '0) |-> !luse_o);
endmodule

// File: rtl/hzd_squash.sv
module hzd_squash
  import hzd_pkg::*;
#(
  parameter res_stage_e RES_STAGE  = RES_EX,
  parameter bit         DELAY_SLOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ifid_vld_i,
  input  logic idex_vld_i,
  input  logic br_taken_i,
  output logic take_o,
  output logic ifid_flush_o,
  output logic idex_flush_o
);
  localparam int DEPTH = squash_depth(RES_STAGE, DELAY_SLOT);

  // branch only counts from an occupied resolving stage
  generate
    if (RES_STAGE == RES_EX) begin : g_res_ex
      assign take_o = br_taken_i && idex_vld_i;
    end else begin : g_res_id
      assign take_o = br_taken_i && ifid_vld_i;
    end
  endgenerate

  generate
    if (DEPTH >= 2) begin : g_d2
      assign ifid_flush_o = take_o;
      assign idex_flush_o = take_o;
      // R6
      two_deep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ifid_flush_o |-> idex_flush_o);
    end else if (DEPTH == 1) begin : g_d1
      assign ifid_flush_o = take_o;
      assign idex_flush_o = 1'b0;
      // R7
      one_deep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ifid_flush_o |-> !idex_flush_o);
    end else begin : g_d0
      assign ifid_flush_o = 1'b0;
      assign idex_flush_o = 1'b0;
      // R8
      no_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> !ifid_flush_o && !idex_flush_o);
    end
  endgenerate
endmodule

// File: rtl/hzd_valid_track.sv
module hzd_valid_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ifid_we_i,
  input  logic ifid_flush_i,
  input  logic idex_clear_i,
  output logic ifid_vld_o,
  output logic idex_vld_o
);
  logic ifid_q, idex_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_q <= 1'b0;
      idex_q <= 1'b0;
    end else begin
      if (ifid_flush_i)   ifid_q <= 1'b0;
      else if (ifid_we_i) ifid_q <= 1'b1;
      idex_q <= idex_clear_i ? 1'b0 : ifid_q;
    end
  end

  assign ifid_vld_o = ifid_q;
  assign idex_vld_o = idex_q;

  // R11
  ifid_flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_i |=> !ifid_vld_o);
  // R11
  idex_clear_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_clear_i |=> !idex_vld_o);
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int         RW         = 5,
  parameter int         AW         = 32,
  parameter res_stage_e RES_STAGE  = RES_EX,
  parameter bit         DELAY_SLOT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ifid_rs1_i,
  input  logic [RW-1:0] ifid_rs2_i,
  input  logic          idex_load_i,
  input  logic [RW-1:0] idex_rd_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic          pc_we_o,
  output logic          ifid_we_o,
  output logic          idex_bubble_o,
  output logic          ifid_flush_o,
  output logic          idex_flush_o,
  output logic          pc_redirect_o,
  output logic [AW-1:0] pc_target_o,
  output logic          ifid_vld_o,
  output logic          idex_vld_o
);
  logic luse, take, stall, ifid_vld, idex_vld;

  hzd_load_use #(.RW(RW)) u_luse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ifid_vld_i (ifid_vld),
    .idex_vld_i (idex_vld),
    .rs1_i      (ifid_rs1_i),
    .rs2_i      (ifid_rs2_i),
    .load_i     (idex_load_i),
    .rd_i       (idex_rd_i),
    .luse_o     (luse)
  );

  hzd_squash #(.RES_STAGE(RES_STAGE), .DELAY_SLOT(DELAY_SLOT)) u_sq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ifid_vld_i   (ifid_vld),
    .idex_vld_i   (idex_vld),
    .br_taken_i   (br_taken_i),
    .take_o       (take),
    .ifid_flush_o (ifid_flush_o),
    .idex_flush_o (idex_flush_o)
  );

  // taken branch overrides the stall
  assign stall         = luse && !take;
  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;
  assign pc_redirect_o = take;
  assign pc_target_o   = take ? br_target_i : '0;

  hzd_valid_track u_vt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ifid_we_i    (ifid_we_o),
    .ifid_flush_i (ifid_flush_o),
    .idex_clear_i (idex_bubble_o || idex_flush_o),
    .ifid_vld_o   (ifid_vld),
    .idex_vld_o   (idex_vld)
  );

  assign ifid_vld_o = ifid_vld;
  assign idex_vld_o = idex_vld;

  // R3
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> !pc_we_o && !ifid_we_o);
  // R4
  stall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |=> !idex_bubble_o && !idex_vld_o);
  // R9
  flush_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_redirect_o |-> !idex_bubble_o && pc_we_o);
  // R6
  target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_redirect_o |-> pc_target_o == br_target_i);
  // R10
  empty_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ifid_vld_o && !idex_vld_o) |-> !pc_redirect_o && !idex_bubble_o);
endmodule

// File: tb/hzd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hzd_ctrl_tb_top;
  import hzd_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  rs1 = '0, rs2 = '0, rd = '0;
  logic        ld = 1'b0, br = 1'b0;
  logic [31:0] tgt = '0;

  logic        o_pcwe [4], o_ifwe [4], o_bub [4], o_iff [4], o_idf [4];
  logic        o_red [4], o_ifv [4], o_idv [4];
  logic [31:0] o_tgt [4];

  // cfg 0: EX, 1: EX+slot, 2: ID, 3: ID+slot
  for (genvar k = 0; k < 4; k++) begin : g_cfg
    hzd_ctrl #(
      .RW(5), .AW(32),
      .RES_STAGE(k < 2 ? RES_EX : RES_ID),
      .DELAY_SLOT(k % 2 == 1)
    ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni),
      .ifid_rs1_i(rs1), .ifid_rs2_i(rs2),
      .idex_load_i(ld), .idex_rd_i(rd),
      .br_taken_i(br), .br_target_i(tgt),
      .pc_we_o(o_pcwe[k]), .ifid_we_o(o_ifwe[k]), .idex_bubble_o(o_bub[k]),
      .ifid_flush_o(o_iff[k]), .idex_flush_o(o_idf[k]),
      .pc_redirect_o(o_red[k]), .pc_target_o(o_tgt[k]),
      .ifid_vld_o(o_ifv[k]), .idex_vld_o(o_idv[k])
    );
  end

  int total = 0, bad = 0;
  bit m_if [4], m_ix [4];
  bit finished = 0;

  task automatic step(input logic [4:0] a, input logic [4:0] b, input logic l,
                      input logic [4:0] d, input logic t, input logic [31:0] ta,
                      input string tag);
    bit e_iff [4], e_idf [4], e_bub [4], e_we [4];
    rs1 = a; rs2 = b; ld = l; rd = d; br = t; tgt = ta;
    #3;
    for (int k = 0; k < 4; k++) begin
      bit ex, ds, take, st;
      int depth;
      logic [39:0] act, exp;
      ex = (k < 2); ds = (k % 2 == 1);
      depth = (ex ? 2 : 1) - (ds ? 1 : 0);
      take = t && (ex ? m_ix[k] : m_if[k]);
      st = !take && m_if[k] && m_ix[k] && l && (d != 0) && (d == a || d == b);
      e_we[k] = !st; e_bub[k] = st;
      e_iff[k] = take && depth >= 1;
      e_idf[k] = take && depth >= 2;
      exp = {e_we[k], e_we[k], e_bub[k], e_iff[k], e_idf[k], take,
             m_if[k], m_ix[k], take ? ta : 32'h0};
      act = {o_pcwe[k], o_ifwe[k], o_bub[k], o_iff[k], o_idf[k], o_red[k],
             o_ifv[k], o_idv[k], o_tgt[k]};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s cfg=%0d act=%h exp=%h", tag, k, act, exp);
      end
    end
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      bit nif;
      nif = e_iff[k] ? 1'b0 : (e_we[k] ? 1'b1 : m_if[k]);
      m_ix[k] = (e_bub[k] || e_idf[k]) ? 1'b0 : m_if[k];
      m_if[k] = nif;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin m_if[k] = 0; m_ix[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 outputs while held in reset
    for (int k = 0; k < 4; k++) begin
      total++;
      if (o_ifv[k] !== 1'b0 || o_idv[k] !== 1'b0 || o_red[k] !== 1'b0) begin
        bad++;
        $display("FAIL R1 cfg=%0d act=%b%b%b exp=000", k, o_ifv[k], o_idv[k], o_red[k]);
      end
    end
    rst_ni = 1'b1;
    step(5'd3, 5'd3, 1'b1, 5'd3, 1'b1, 32'h10, "R1");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 32'h20, "R10");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 32'h0, "R2 R3");
    step(5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 32'h0, "R4");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd7, 5'd9, 1'b1, 5'd9, 1'b0, 32'h0, "R2 R3");
    step(5'd7, 5'd9, 1'b1, 5'd9, 1'b0, 32'h0, "R4");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd0, 5'd6, 1'b1, 5'd0, 1'b0, 32'h0, "R5");
    step(5'd1, 5'd2, 1'b1, 5'd5, 1'b0, 32'h0, "R2");
    step(5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 32'h0, "R2");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 32'h40, "R6 R7 R8");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 32'h80, "R10");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd8, 5'd2, 1'b1, 5'd8, 1'b1, 32'hC0, "R9");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0, "R11");
    step(5'd2, 5'd8, 1'b1, 5'd8, 1'b0, 32'h0, "R3");
    step(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 32'h100, "R6 R7 R8");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule